// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Hit Timestamper

The block watches 24 digital pulse lines. Each line comes from a converter that turns a detector pulse into a rectangle: the leading edge marks when the hit happened and the length of the rectangle grows with the collected charge. Every line is resynchronised to the core clock. The block stamps the leading edge and the trailing edge of each pulse with a shared coarse counter. The counter can be loaded from outside, so that it follows a detector-wide reference time. The block then derives the pulse width from the two stamps.

A completed hit becomes a record that holds the channel number, the leading-edge time, a 16-bit width and a saturation flag. Each channel keeps its records in a small FIFO. A round-robin arbiter merges all channels into a single valid/ready stream. A programmable dead time after each accepted pulse rejects retriggers. Each channel counts its completed hits, its rejected retriggers and the records it has had to drop. A strobe captures the hit count for readback and restarts it. A channel select input picks which channel's counters appear at the status outputs.

Top module: `pulse_stamper`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and all three status outputs read 0 for every channel.
- R2: The coarse counter starts at 0 and advances by one each clock. When `ts_load` is high at a clock edge, the counter takes `ts_load_val` at that edge instead of advancing.
- R3: A record's `out_time` equals the counter value two clocks after the input line goes high. The two clocks are the synchroniser delay.
- R4: `out_width` equals the falling-edge stamp minus the rising-edge stamp, modulo 2^32. This is the number of clocks the line was high, and it stays correct when the counter wraps between the two edges.
- R5: When the width exceeds 65535, `out_width` reads 16'hFFFF and `out_sat` is 1. Otherwise `out_sat` is 0.
- R6: After an accepted pulse falls, a rising edge that follows a low gap of `dead_time` clocks or fewer is discarded. A discarded pulse produces no record and no hit count, and it increments that channel's reject counter. A gap longer than `dead_time` is accepted.
- R7: `out_chan` carries the binary index (0 to 23) of the channel that produced the record. Records from one channel leave in the order the hits occurred.
- R8: When several channels hold records, the grant rotates, starting the search after the last channel served. Two channels that each hold records are served alternately.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and the record fields hold their values.
- R10: A hit that completes while its channel FIFO is full is discarded and increments that channel's drop counter. It still counts as a completed hit.
- R11: A one-clock `stat_strobe` copies each channel's completed-hit count into its readable latch and restarts the count. A hit that completes in the same clock as the strobe is counted in the new period.
- R12: `stat_sel` chooses the channel whose latched hit count, reject count and drop count appear on `stat_hits`, `stat_rejects` and `stat_drops`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 24 | Asynchronous pulse lines, one per channel |
| ts_load | input | 1 | Load strobe for the coarse counter |
| ts_load_val | input | 32 | Value loaded into the coarse counter |
| dead_time | input | 8 | Retrigger guard window in clocks |
| stat_strobe | input | 1 | Capture and restart the hit counts |
| stat_sel | input | 5 | Channel whose counters are shown |
| stat_hits | output | 16 | Latched completed-hit count of the selected channel |
| stat_rejects | output | 16 | Dead-time reject count of the selected channel |
| stat_drops | output | 16 | FIFO-full drop count of the selected channel |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Downstream accepts the record |
| out_chan | output | 5 | Channel index of the record |
| out_time | output | 32 | Rising-edge timestamp |
| out_width | output | 16 | Pulse width in clocks, saturating |
| out_sat | output | 1 | Width saturated |

## Verification
Two events can land in the same clock: a hit completes (its falling edge is detected), and the status strobe captures and restarts that channel's hit counter. The bench provokes this by raising `stat_strobe` exactly two clocks after it lowers a channel's pulse, so the strobe coincides with the falling-edge detection. The bench then expects the latched count to exclude that hit. A second strobe must show a count of one, which proves the hit was carried into the new period and not lost. Arbitration under back-pressure gets the same treatment: two channels fire together while the output is stalled, and the order of the drained records must alternate between them.

// File: rtl/pst_pkg.sv
// Shared record layout for the hit timestamper.
// Assumes a 32-bit coarse time and a 16-bit saturating width field.
package pst_pkg;
    localparam int TS_W  = 32;
    localparam int WID_W = 16;

    typedef struct packed {
        logic [TS_W-1:0]  t;    // rising-edge stamp
        logic [WID_W-1:0] w;    // width in clocks
        logic             sat;  // width clipped
    } hit_rec_t;

    localparam int REC_W = $bits(hit_rec_t);
endpackage

// File: rtl/pst_ts_counter.sv
// Coarse timestamp counter. Advances once per clock and can be loaded
// from an external reference. Assumes the load value is already aligned
// to the clock domain.
module pst_ts_counter
    import pst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    output logic [TS_W-1:0] ts
);

    // Count or take the external value.
    always_ff @(posedge clk) begin
        if (!rst_n)    ts <= '0;
        else if (load) ts <= load_val;
        else           ts <= ts + 1'b1;
    end

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ts == $past(ts) + 1'b1); // R2
    AST_TS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ts == $past(load_val)); // R2

endmodule

// File: rtl/pst_chan_front.sv
// One channel front end: resynchronises the pulse, stamps both edges,
// applies the retrigger guard, builds the record and keeps the counters.
// Assumes the pulse is asynchronous and at least one clock wide.
module pst_chan_front
    import pst_pkg::*;
#(
    parameter int DT_W  = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic [TS_W-1:0]  ts,
    input  logic [DT_W-1:0]  dead_time,
    input  logic             strobe,
    input  logic             full,
    output logic             push,
    output hit_rec_t         rec,
    output logic [CNT_W-1:0] hits_l,
    output logic [CNT_W-1:0] rejects,
    output logic [CNT_W-1:0] drops
);

    logic [2:0]       sync_q;
    logic             in_pulse;
    logic [DT_W-1:0]  dcnt;
    logic [TS_W-1:0]  rise_ts;
    logic [TS_W-1:0]  span;
    logic [CNT_W-1:0] hit_cnt;
    logic             rise, fall, accept, reject, done;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pulse};
    end

    // Edge classification and record assembly.
    always_comb begin
        rise    = sync_q[1] & ~sync_q[2];
        fall    = ~sync_q[1] & sync_q[2];
        accept  = rise & ~in_pulse & (dcnt == '0);
        reject  = rise & ~in_pulse & (dcnt != '0);
        done    = fall & in_pulse;
        span    = ts - rise_ts;
        rec.t   = rise_ts;
        rec.sat = |span[TS_W-1:WID_W];
        rec.w   = rec.sat ? '1 : span[WID_W-1:0];
        push    = done & ~full;
    end

    // Pulse tracking and dead-time window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pulse <= 1'b0;
            rise_ts  <= '0;
            dcnt     <= '0;
        end else begin
            if (accept) begin
                in_pulse <= 1'b1;
                rise_ts  <= ts;
            end
            if (done) begin
                in_pulse <= 1'b0;
                dcnt     <= dead_time;
            end else if (dcnt != '0) begin
                dcnt <= dcnt - 1'b1;
            end
        end
    end

    // Reject and drop counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rejects <= '0;
            drops   <= '0;
        end else begin
            if (reject)      rejects <= rejects + 1'b1;
            if (done & full) drops   <= drops + 1'b1;
        end
    end

    // Completed-hit count with capture-and-restart strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt <= '0;
            hits_l  <= '0;
        end else if (strobe) begin
            hits_l  <= hit_cnt;
            hit_cnt <= done ? CNT_W'(1) : '0;
        end else if (done) begin
            hit_cnt <= hit_cnt + 1'b1;
        end
    end

    AST_DEAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_pulse |-> dcnt == '0); // R6

endmodule

// File: rtl/pst_fifo.sv
// Small per-channel record FIFO. Assumes DEPTH is a power of two of at
// least 2 and that the writer never pushes while full.
module pst_fifo #(
    parameter int DW    = 49,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full
);

    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));

    AST_FIFO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10
    AST_FIFO_NO_UDF: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8

endmodule

// File: rtl/pst_rr_merge.sv
// Round-robin merge of per-channel FIFOs into one registered
// valid/ready output. The search starts after the last channel served.
module pst_rr_merge #(
    parameter int NCH = 24,
    parameter int DW  = 49
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           req,
    input  logic [NCH-1:0][DW-1:0]   data,
    output logic [NCH-1:0]           pop,
    input  logic                     ready,
    output logic                     valid,
    output logic [$clog2(NCH)-1:0]   chan,
    output logic [DW-1:0]            dout
);

    localparam int CW = $clog2(NCH);

    logic [CW-1:0]  last;
    logic [CW-1:0]  gidx;
    logic [NCH-1:0] gnt;
    logic           found;
    logic           take;

    assign take = ~valid | ready;

    // Rotating-priority search for the next requester.
    always_comb begin : p_grant
        int idx;
        idx   = 0;
        gnt   = '0;
        gidx  = '0;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            idx = (int'(last) + 1 + i) % NCH;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                gidx     = CW'(idx);
                found    = 1'b1;
            end
        end
    end

    assign pop = take ? gnt : '0;

    // Output register load and priority pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            chan  <= '0;
            dout  <= '0;
            last  <= CW'(NCH-1);
        end else if (take) begin
            valid <= found;
            if (found) begin
                chan <= gidx;
                dout <= data[gidx];
                last <= gidx;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(chan) && $stable(dout)); // R9

endmodule

// File: rtl/pulse_stamper.sv
// Top of the multi-channel pulse-width hit timestamper. Instantiates the
// shared counter, one front end and FIFO per channel, and the merge.
// Assumes all inputs except pulse_in are synchronous to clk.
module pulse_stamper
    import pst_pkg::*;
#(
    parameter int NCH        = 24,
    parameter int FIFO_DEPTH = 4,
    parameter int DT_W       = 8,
    parameter int CNT_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         pulse_in,
    input  logic                   ts_load,
    input  logic [TS_W-1:0]        ts_load_val,
    input  logic [DT_W-1:0]        dead_time,
    input  logic                   stat_strobe,
    input  logic [$clog2(NCH)-1:0] stat_sel,
    output logic [CNT_W-1:0]       stat_hits,
    output logic [CNT_W-1:0]       stat_rejects,
    output logic [CNT_W-1:0]       stat_drops,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [$clog2(NCH)-1:0] out_chan,
    output logic [TS_W-1:0]        out_time,
    output logic [WID_W-1:0]       out_width,
    output logic                   out_sat
);

    logic [TS_W-1:0]            ts_now;
    logic [NCH-1:0]             f_push, f_full, f_empty, m_req, m_pop;
    hit_rec_t                   f_rec [NCH];
    logic [NCH-1:0][REC_W-1:0]  m_data;
    logic [REC_W-1:0]           m_out;
    hit_rec_t                   rec_o;
    logic [CNT_W-1:0]           hits_l [NCH];
    logic [CNT_W-1:0]           rej_c  [NCH];
    logic [CNT_W-1:0]           drp_c  [NCH];

    pst_ts_counter u_ts (
        .clk, .rst_n, .load(ts_load), .load_val(ts_load_val), .ts(ts_now)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pst_chan_front #(.DT_W(DT_W), .CNT_W(CNT_W)) u_front (
            .clk, .rst_n,
            .pulse(pulse_in[g]), .ts(ts_now), .dead_time,
            .strobe(stat_strobe), .full(f_full[g]),
            .push(f_push[g]), .rec(f_rec[g]),
            .hits_l(hits_l[g]), .rejects(rej_c[g]), .drops(drp_c[g])
        );
        pst_fifo #(.DW(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk, .rst_n,
            .push(f_push[g]), .din(f_rec[g]), .pop(m_pop[g]),
            .dout(m_data[g]), .empty(f_empty[g]), .full(f_full[g])
        );
        assign m_req[g] = ~f_empty[g];
    end

    pst_rr_merge #(.NCH(NCH), .DW(REC_W)) u_merge (
        .clk, .rst_n, .req(m_req), .data(m_data), .pop(m_pop),
        .ready(out_ready), .valid(out_valid), .chan(out_chan), .dout(m_out)
    );

    // Unpack the merged record onto the output fields.
    always_comb begin
        rec_o     = hit_rec_t'(m_out);
        out_time  = rec_o.t;
        out_width = rec_o.w;
        out_sat   = rec_o.sat;
    end

    // Status readback mux for the selected channel.
    always_comb begin
        stat_hits    = '0;
        stat_rejects = '0;
        stat_drops   = '0;
        if (int'(stat_sel) < NCH) begin
            stat_hits    = hits_l[stat_sel];
            stat_rejects = rej_c[stat_sel];
            stat_drops   = drp_c[stat_sel];
        end
    end

endmodule

// File: tb/sim_pulse_stamper.sv
`timescale 1ns/1ps
module sim_pulse_stamper;
    localparam int NCH = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pulse_in = '0;
    logic        ts_load = 1'b0;
    logic [31:0] ts_load_val = '0;
    logic [7:0]  dead_time = '0;
    logic        stat_strobe = 1'b0;
    logic [4:0]  stat_sel = '0;
    logic        out_ready = 1'b1;
    logic [15:0] stat_hits, stat_rejects, stat_drops;
    logic        out_valid, out_sat;
    logic [4:0]  out_chan;
    logic [31:0] out_time;
    logic [15:0] out_width;

    always #2 clk = ~clk;

    pulse_stamper u0 (
        .clk, .rst_n, .pulse_in, .ts_load, .ts_load_val, .dead_time,
        .stat_strobe, .stat_sel, .stat_hits, .stat_rejects, .stat_drops,
        .out_valid, .out_ready, .out_chan, .out_time, .out_width, .out_sat
    );

    typedef struct {
        int          ch;
        logic [31:0] t;
        logic [15:0] w;
        logic        sat;
    } exp_t;

    exp_t        sb[$];
    int          seq[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] m_ts;

    // Reference time per R2.
    always @(posedge clk) begin
        if (!rst_n)       m_ts <= '0;
        else if (ts_load) m_ts <= ts_load_val;
        else              m_ts <= m_ts + 32'd1;
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rec(int ch, logic [31:0] t0, int h);
        exp_t e;
        e.ch  = ch;
        e.t   = t0;
        e.sat = (h > 65535);
        e.w   = e.sat ? 16'hFFFF : h[15:0];
        sb.push_back(e);
    endtask

    // Driver: one pulse of h clocks on channel ch (R3 latency of two).
    task automatic pulse(int ch, int h, bit keep);
        logic [31:0] t0;
        pulse_in[ch] = 1'b1;
        t0 = m_ts + 32'd2;
        repeat (h) @(negedge clk);
        pulse_in[ch] = 1'b0;
        if (keep) expect_rec(ch, t0, h);
    endtask

    task automatic pulse_pair(int a, int b, int h);
        logic [31:0] t0;
        pulse_in[a] = 1'b1;
        pulse_in[b] = 1'b1;
        t0 = m_ts + 32'd2;
        repeat (h) @(negedge clk);
        pulse_in[a] = 1'b0;
        pulse_in[b] = 1'b0;
        expect_rec(a, t0, h);
        expect_rec(b, t0, h);
    endtask

    task automatic sel(int ch);
        stat_sel = ch[4:0];
        #1;
    endtask

    // Monitor: match each transferred record against the scoreboard.
    always @(negedge clk) begin
        int k;
        #1;
        k = -1;
        if (rst_n && out_valid && out_ready) begin
            for (int i = 0; i < sb.size(); i++)
                if (k < 0 && sb[i].ch == int'(out_chan)) k = i;
            checks++;
            if (k < 0) begin
                errors++;
                $display("FAIL R7 unexpected record actual=%0d expected=none", out_chan);
            end else begin
                check("R3 time", out_time, sb[k].t);
                check("R4 width", out_width, sb[k].w);
                check("R5 sat", out_sat, sb[k].sat);
                sb.delete(k);
                seq.push_back(int'(out_chan));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", out_valid, 0);
        sel(0);
        check("R1 hits", stat_hits, 0);
        check("R1 rejects", stat_rejects, 0);
        check("R1 drops", stat_drops, 0);

        // Basic hits, several widths and channels
        pulse(5, 1, 1);  idle(4);
        pulse(5, 9, 1);  idle(3);
        pulse(23, 7, 1); idle(20);
        check("R3 drain basic", sb.size(), 0);

        // R2 load then R4 width across counter wrap
        ts_load = 1'b1;
        ts_load_val = 32'hFFFF_FFFC;
        @(negedge clk);
        ts_load = 1'b0;
        pulse(7, 6, 1); idle(20);
        check("R4 drain wrap", sb.size(), 0);

        // R6 dead time: gap 3 rejected, gap 4 accepted
        dead_time = 8'd3;
        pulse(2, 4, 1); idle(3);
        pulse(2, 2, 0); idle(10);
        pulse(2, 5, 1); idle(4);
        pulse(2, 3, 1); idle(20);
        sel(2);
        check("R6 rejects", stat_rejects, 1);
        check("R6 drain", sb.size(), 0);
        dead_time = 8'd0;

        // R8 round robin under back-pressure
        out_ready = 1'b0;
        seq.delete();
        pulse_pair(3, 9, 2); idle(3);
        pulse_pair(3, 9, 2); idle(10);
        check("R9 valid held", out_valid, 1);
        out_ready = 1'b1;
        idle(20);
        check("R8 count", seq.size(), 4);
        for (int i = 0; i + 1 < seq.size(); i++)
            check("R8 alternate", seq[i] != seq[i+1], 1);

        // R5 saturation
        pulse(11, 70000, 1); idle(20);
        check("R5 drain", sb.size(), 0);

        // R10 FIFO full drops, R9 hold while stalled
        out_ready = 1'b0;
        for (int i = 0; i < 7; i++) begin
            pulse(0, 2, i < 5);
            idle(2);
        end
        idle(5);
        check("R9 valid", out_valid, 1);
        check("R7 chan", out_chan, 0);
        check("R9 time", out_time, sb[0].t);
        sel(0);
        check("R10 drops", stat_drops, 2);
        out_ready = 1'b1;
        idle(20);
        check("R10 drain", sb.size(), 0);

        // R11 strobe in the same clock as a hit completion
        pulse(0, 3, 1);
        idle(2);
        stat_strobe = 1'b1;
        @(negedge clk);
        stat_strobe = 1'b0;
        sel(0);
        check("R11 latched", stat_hits, 7);
        sel(2);
        check("R12 ch2 hits", stat_hits, 3);
        sel(11);
        check("R12 ch11 hits", stat_hits, 1);
        idle(20);
        stat_strobe = 1'b1;
        @(negedge clk);
        stat_strobe = 1'b0;
        sel(0);
        check("R11 carried", stat_hits, 1);
        sel(2);
        check("R12 ch2 cleared", stat_hits, 0);
        check("R11 drain", sb.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule